// File: doc/BRIEF.md
# Pre-add Multiply Accumulate Slice

The block is one arithmetic slice for a datapath that multiplies, adds and accumulates. A signed pre-adder forms the sum or difference of two operands. That result is multiplied by a third operand. Three operand selectors then choose what reaches an adder/subtractor, whose result is kept in a registered output. The selectors can pick the product, the slice's own output fed back, a side input, a cascade input from a neighbouring slice, or copies of the cascade input or the feedback shifted right by 17 bits.

Slices are chained by wiring one slice's cascade output to the next slice's cascade input. The shifted paths allow several narrow multipliers to be combined into a wider one. A masked comparator watches the registered result and raises a flag on a match. It can also clear the result on the following update, either when the result matches or when it does not.

Top module: `pmac_slice`

## Requirements
- R1: The product is the signed value (a + d) × b when `pre_sub`=0 and (a − d) × b when `pre_sub`=1, with a, d and b all taken as two's complement. The product is sign-extended to the output width.
- R2: The X operand is 0 for `xsel`=00, the product for 01, the current `p` for 10, and the zero-extended concatenation {a, b} (a in the upper bits) for 11.
- R3: The Y operand is 0 for `ysel`=00, all ones for 10, and `c` for 11. For 01 it is the product, except that it is 0 when `xsel`=01 as well, so the product is counted only once.
- R4: The Z operand is 0 for `zsel`=000, `pcin` for 001, `p` for 010 and for 100, and `c` for 011.
- R5: The Z operand is `pcin` shifted arithmetically right by 17 bits for `zsel`=101, and `p` shifted arithmetically right by 17 bits for 110.
- R6: On a rising clock edge with `ce`=1, `p` takes Z + (X + Y) when `sub`=0 and Z − (X + Y) when `sub`=1, wrapped to the output width.
- R7: With `ce`=0, `p` keeps its value. `pcout` always equals `p`.
- R8: While `zsel`=111, `sel_err` is 1 and an enabled edge leaves `p` unchanged. For every other code `sel_err` is 0.
- R9: `pat_hit` is 1 exactly when every bit of `p` whose mask bit is 0 equals the matching reference bit. The default mask is 24'hFFF000 (1 means the bit is ignored). The reference is the constant 24'h000ABC when `pat_src`=0 and `c` when `pat_src`=1.
- R10: With `clr_mode`=01 and `pat_hit`=1, or with `clr_mode`=10 and `pat_hit`=0, an enabled edge loads 0 into `p`. This overrides R6 and R8. `clr_mode` values 00 and 11 never clear.
- R11: While `rst_n` is low, `p` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce | input | 1 | Update enable for the result register |
| pre_sub | input | 1 | Pre-adder subtracts d when 1 |
| sub | input | 1 | ALU subtracts X+Y from Z when 1 |
| xsel | input | 2 | X operand select |
| ysel | input | 2 | Y operand select |
| zsel | input | 3 | Z operand select |
| pat_src | input | 1 | Comparator reference: 0 constant, 1 input c |
| clr_mode | input | 2 | Auto-clear: 01 on match, 10 on mismatch |
| a | input | AW (12) | Pre-adder operand |
| d | input | AW (12) | Pre-adder operand |
| b | input | BW (9) | Multiplier operand |
| c | input | PW (24) | Side operand and optional reference |
| pcin | input | PW (24) | Cascade input from the previous slice |
| p | output | PW (24) | Registered result |
| pcout | output | PW (24) | Cascade output to the next slice |
| pat_hit | output | 1 | Masked compare match on p |
| sel_err | output | 1 | Illegal Z select code present |

## Verification
The operands pass through no register before the result, so `p` and `pcout` show the outcome of a stimulus one rising edge after it is applied. `pat_hit` and `sel_err` are combinational: `pat_hit` follows the updated `p` and the inputs still held in that cycle, and `sel_err` follows `zsel` directly. The driver applies each stimulus on a falling edge and queues the expected result together with the expected flags. The monitor pops the queue one nanosecond after the next rising edge and compares all of them at that point. The expected values come from a wide-integer model kept in the bench.

// File: rtl/pmac_pkg.sv
package pmac_pkg;
  localparam int unsigned CASC_SHIFT = 17;

  typedef enum logic [1:0] {X_ZERO = 2'b00, X_PROD = 2'b01, X_FBK = 2'b10, X_CAT = 2'b11} xsel_e;
  typedef enum logic [1:0] {Y_ZERO = 2'b00, Y_PROD = 2'b01, Y_ONES = 2'b10, Y_SIDE = 2'b11} ysel_e;
  typedef enum logic [2:0] {
    Z_ZERO = 3'b000, Z_CASC = 3'b001, Z_FBK = 3'b010, Z_SIDE = 3'b011,
    Z_FBK2 = 3'b100, Z_CASC_SH = 3'b101, Z_FBK_SH = 3'b110, Z_BAD = 3'b111
  } zsel_e;
  typedef enum logic [1:0] {CLR_OFF = 2'b00, CLR_HIT = 2'b01, CLR_MISS = 2'b10, CLR_OFF2 = 2'b11} clr_e;
endpackage

// File: rtl/pmac_premul.sv
module pmac_premul #(
  parameter int AW = 12,
  parameter int BW = 9,
  localparam int MW = AW + 1 + BW
) (
  input  logic                 pre_sub,
  input  logic [AW-1:0]        a,
  input  logic [AW-1:0]        d,
  input  logic [BW-1:0]        b,
  output logic signed [MW-1:0] prod
);
  function automatic logic signed [AW:0] pre_op(input logic [AW-1:0] x, input logic [AW-1:0] y,
                                                input logic neg);
    logic signed [AW:0] xe, ye;
    xe = {x[AW-1], x};
    ye = {y[AW-1], y};
    return neg ? (xe - ye) : (xe + ye);
  endfunction

  function automatic logic signed [MW-1:0] smul(input logic signed [AW:0] x,
                                                input logic signed [BW-1:0] y);
    logic signed [MW-1:0] xe, ye;
    xe = MW'(x);
    ye = MW'(y);
    return xe * ye;
  endfunction

  logic signed [AW:0] pre_sum;
  assign pre_sum = pre_op(a, d, pre_sub);
  assign prod    = smul(pre_sum, $signed(b));
endmodule

// File: rtl/pmac_opsel.sv
module pmac_opsel
  import pmac_pkg::*;
#(
  parameter int AW = 12,
  parameter int BW = 9,
  parameter int PW = 24,
  localparam int MW = AW + 1 + BW
) (
  input  logic [1:0]           xsel,
  input  logic [1:0]           ysel,
  input  logic [2:0]           zsel,
  input  logic signed [MW-1:0] prod,
  input  logic [PW-1:0]        p,
  input  logic [PW-1:0]        c,
  input  logic [PW-1:0]        pcin,
  input  logic [AW-1:0]        a,
  input  logic [BW-1:0]        b,
  output logic [PW-1:0]        x_op,
  output logic [PW-1:0]        y_op,
  output logic [PW-1:0]        z_op,
  output logic                 illegal
);
  logic [PW-1:0]        prod_ext;
  logic signed [PW-1:0] p_s, pcin_s;

  assign prod_ext = {{(PW-MW){prod[MW-1]}}, prod};
  assign p_s      = p;
  assign pcin_s   = pcin;

  always_comb begin
    unique case (xsel_e'(xsel))
      X_ZERO:  x_op = '0;
      X_PROD:  x_op = prod_ext;
      X_FBK:   x_op = p;
      default: x_op = {{(PW-AW-BW){1'b0}}, a, b};
    endcase
  end

  always_comb begin
    unique case (ysel_e'(ysel))
      Y_ZERO:  y_op = '0;
      Y_PROD:  y_op = (xsel_e'(xsel) == X_PROD) ? '0 : prod_ext;
      Y_ONES:  y_op = '1;
      default: y_op = c;
    endcase
  end

  always_comb begin
    illegal = 1'b0;
    unique case (zsel_e'(zsel))
      Z_ZERO:         z_op = '0;
      Z_CASC:         z_op = pcin;
      Z_FBK, Z_FBK2:  z_op = p;
      Z_SIDE:         z_op = c;
      Z_CASC_SH:      z_op = pcin_s >>> CASC_SHIFT;
      Z_FBK_SH:       z_op = p_s >>> CASC_SHIFT;
      default: begin
        z_op    = p;
        illegal = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/pmac_patdet.sv
module pmac_patdet #(
  parameter int          PW      = 24,
  parameter logic [PW-1:0] PATTERN = 24'h000ABC,
  parameter logic [PW-1:0] MASK    = 24'hFFF000
) (
  input  logic [PW-1:0] p,
  input  logic [PW-1:0] c,
  input  logic          pat_src,
  output logic          hit
);
  function automatic logic masked_eq(input logic [PW-1:0] v, input logic [PW-1:0] ref_v);
    return ((v ^ ref_v) & ~MASK) == '0;
  endfunction

  assign hit = masked_eq(p, pat_src ? c : PATTERN);
endmodule

// File: rtl/pmac_slice.sv
module pmac_slice
  import pmac_pkg::*;
#(
  parameter int            AW      = 12,
  parameter int            BW      = 9,
  parameter int            PW      = 24,
  parameter logic [PW-1:0] PATTERN = 24'h000ABC,
  parameter logic [PW-1:0] MASK    = 24'hFFF000,
  localparam int           MW      = AW + 1 + BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce,
  input  logic          pre_sub,
  input  logic          sub,
  input  logic [1:0]    xsel,
  input  logic [1:0]    ysel,
  input  logic [2:0]    zsel,
  input  logic          pat_src,
  input  logic [1:0]    clr_mode,
  input  logic [AW-1:0] a,
  input  logic [AW-1:0] d,
  input  logic [BW-1:0] b,
  input  logic [PW-1:0] c,
  input  logic [PW-1:0] pcin,
  output logic [PW-1:0] p,
  output logic [PW-1:0] pcout,
  output logic          pat_hit,
  output logic          sel_err
);
  function automatic logic [PW-1:0] alu(input logic [PW-1:0] zv, input logic [PW-1:0] xv,
                                        input logic [PW-1:0] yv, input logic neg);
    logic [PW-1:0] s;
    s = xv + yv;
    return neg ? (zv - s) : (zv + s);
  endfunction

  logic signed [MW-1:0] prod;
  logic [PW-1:0]        x_op, y_op, z_op, alu_out;
  logic                 clr_now, upd_now;

  pmac_premul #(.AW(AW), .BW(BW)) u_premul (
    .pre_sub(pre_sub), .a(a), .d(d), .b(b), .prod(prod)
  );

  pmac_opsel #(.AW(AW), .BW(BW), .PW(PW)) u_opsel (
    .xsel(xsel), .ysel(ysel), .zsel(zsel), .prod(prod), .p(p), .c(c), .pcin(pcin),
    .a(a), .b(b), .x_op(x_op), .y_op(y_op), .z_op(z_op), .illegal(sel_err)
  );

  pmac_patdet #(.PW(PW), .PATTERN(PATTERN), .MASK(MASK)) u_patdet (
    .p(p), .c(c), .pat_src(pat_src), .hit(pat_hit)
  );

  assign alu_out = alu(z_op, x_op, y_op, sub);
  assign clr_now = ((clr_e'(clr_mode) == CLR_HIT) && pat_hit) ||
                   ((clr_e'(clr_mode) == CLR_MISS) && !pat_hit);
  assign upd_now = ce && !sel_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             p <= '0;
    else if (ce && clr_now) p <= '0;
    else if (upd_now)       p <= alu_out;
  end

  assign pcout = p;
endmodule

// File: rtl/pmac_slice_chk.sv
module pmac_slice_chk #(
  parameter int PW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ce,
  input logic [1:0]    xsel,
  input logic [1:0]    ysel,
  input logic [2:0]    zsel,
  input logic [1:0]    clr_mode,
  input logic          clr_now,
  input logic [PW-1:0] p,
  input logic          pat_hit,
  input logic          sel_err
);
  AST_CE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> $stable(p)); // R7
  AST_BAD_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && zsel == 3'b111 && !clr_now) |=> $stable(p)); // R8
  AST_BAD_SEL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (zsel == 3'b111) |-> sel_err); // R8
  AST_CLR_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && clr_mode == 2'b01 && pat_hit) |=> (p == '0)); // R10
  AST_CLR_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && clr_mode == 2'b10 && !pat_hit) |=> (p == '0)); // R10
  AST_ZERO_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && xsel == 2'b00 && ysel == 2'b00 && zsel == 3'b000) |=> (p == '0)); // R2
endmodule

bind pmac_slice pmac_slice_chk #(.PW(PW)) i_chk (
  .clk(clk), .rst_n(rst_n), .ce(ce), .xsel(xsel), .ysel(ysel), .zsel(zsel),
  .clr_mode(clr_mode), .clr_now(clr_now), .p(p), .pat_hit(pat_hit), .sel_err(sel_err)
);

// File: tb/test_pmac_slice.sv
`timescale 1ns/1ps
module test_pmac_slice;
  localparam logic [23:0] REF_K  = 24'h000ABC;
  localparam logic [23:0] MASK_K = 24'hFFF000;

  typedef struct {
    logic [23:0] p;
    logic        hit;
    logic        err;
    string       tag;
  } exp_t;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        ce = 0, pre_sub = 0, sub = 0, pat_src = 0;
  logic [1:0]  xsel = 0, ysel = 0, clr_mode = 0;
  logic [2:0]  zsel = 0;
  logic [11:0] a = 0, d = 0;
  logic [8:0]  b = 0;
  logic [23:0] c = 0, pcin = 0;
  logic [23:0] p, pcout;
  logic        pat_hit, sel_err;

  int   n_chk = 0, n_err = 0;
  bit   done = 0;
  exp_t q[$];
  logic [23:0] mdl_p = '0;

  always #2.5 clk = ~clk;

  pmac_slice i_pmac_slice (
    .clk(clk), .rst_n(rst_n), .ce(ce), .pre_sub(pre_sub), .sub(sub), .xsel(xsel),
    .ysel(ysel), .zsel(zsel), .pat_src(pat_src), .clr_mode(clr_mode), .a(a), .d(d),
    .b(b), .c(c), .pcin(pcin), .p(p), .pcout(pcout), .pat_hit(pat_hit), .sel_err(sel_err)
  );

  function automatic bit ref_hit(logic [23:0] v, logic [23:0] cv, logic src);
    logic [23:0] r;
    r = src ? cv : REF_K;
    for (int i = 0; i < 24; i++)
      if (!MASK_K[i] && (v[i] != r[i])) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic [23:0] ref_next(logic [23:0] cur);
    longint pr, xv, yv, zv, pv, cv, r;
    pv = longint'($signed(cur));
    cv = longint'($signed(pcin));
    pr = (pre_sub ? (longint'($signed(a)) - longint'($signed(d)))
                  : (longint'($signed(a)) + longint'($signed(d)))) * longint'($signed(b));
    case (xsel)
      2'd0: xv = 0;
      2'd1: xv = pr;
      2'd2: xv = pv;
      default: xv = longint'(a) * 512 + longint'(b);
    endcase
    case (ysel)
      2'd0: yv = 0;
      2'd1: yv = (xsel == 2'd1) ? 0 : pr;
      2'd2: yv = -1;
      default: yv = longint'(c);
    endcase
    case (zsel)
      3'd0: zv = 0;
      3'd1: zv = longint'(pcin);
      3'd2, 3'd4: zv = pv;
      3'd3: zv = longint'(c);
      3'd5: zv = cv >>> 17;
      3'd6: zv = pv >>> 17;
      default: return cur;
    endcase
    r = sub ? (zv - (xv + yv)) : (zv + xv + yv);
    return r[23:0];
  endfunction

  task automatic drive(string tag, logic ce_i, logic ps_i, logic sb_i, logic [1:0] xs,
                       logic [1:0] ys, logic [2:0] zs, logic src, logic [1:0] cm,
                       logic [11:0] av, logic [11:0] dv, logic [8:0] bv,
                       logic [23:0] cv, logic [23:0] pcv);
    exp_t e;
    bit   h, clr;
    @(negedge clk);
    ce = ce_i; pre_sub = ps_i; sub = sb_i; xsel = xs; ysel = ys; zsel = zs;
    pat_src = src; clr_mode = cm; a = av; d = dv; b = bv; c = cv; pcin = pcv;
    h   = ref_hit(mdl_p, cv, src);
    clr = (cm == 2'b01 && h) || (cm == 2'b10 && !h);
    if (ce_i) mdl_p = clr ? 24'h0 : ref_next(mdl_p);
    e.p = mdl_p; e.hit = ref_hit(mdl_p, cv, src); e.err = (zs == 3'b111); e.tag = tag;
    q.push_back(e);
  endtask

  task automatic check(string tag, logic [23:0] act, logic [23:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        check(e.tag, p, e.p);
        check({e.tag, " R7 pcout"}, pcout, e.p);
        check({e.tag, " R9 pat_hit"}, {23'd0, pat_hit}, {23'd0, e.hit});
        check({e.tag, " R8 sel_err"}, {23'd0, sel_err}, {23'd0, e.err});
      end
    end
  end

  initial begin : watchdog
    #(200000 * 5);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    check("R11 reset p", p, 24'h0);
    check("R9 reset pat_hit", {23'd0, pat_hit}, 24'h0);
    rst_n = 1'b1;
    // R1 R2: product alone, add and subtract in the pre-adder
    drive("R1 pre-add",  1, 0, 0, 2'd1, 2'd0, 3'd0, 0, 2'd0, 12'd100, 12'hFEC, 9'd37, 0, 0);
    drive("R1 pre-sub",  1, 1, 0, 2'd1, 2'd0, 3'd0, 0, 2'd0, 12'hF9C, 12'd50, 9'h1F0, 0, 0);
    // R4: accumulate through Z feedback codes 010 and 100
    drive("R4 acc 010",  1, 0, 0, 2'd1, 2'd0, 3'd2, 0, 2'd0, 12'd7, 12'd3, 9'd11, 0, 0);
    drive("R4 acc 100",  1, 0, 0, 2'd1, 2'd0, 3'd4, 0, 2'd0, 12'd7, 12'd3, 9'd11, 0, 0);
    // R3: all ones plus side input
    drive("R3 ones+c",   1, 0, 0, 2'd0, 2'd2, 3'd3, 0, 2'd0, 0, 0, 0, 24'h001000, 0);
    // R2: concatenation
    drive("R2 cat",      1, 0, 0, 2'd3, 2'd0, 3'd0, 0, 2'd0, 12'hABC, 0, 9'h155, 0, 0);
    // R3: product on both X and Y counted once
    drive("R3 once",     1, 0, 0, 2'd1, 2'd1, 3'd0, 0, 2'd0, 12'd9, 12'd1, 9'd5, 0, 0);
    drive("R3 y prod",   1, 0, 0, 2'd0, 2'd1, 3'd0, 0, 2'd0, 12'd9, 12'd1, 9'd5, 0, 0);
    // R2 R3: feedback on X plus c on Y
    drive("R2 fbk+c",    1, 0, 0, 2'd2, 2'd3, 3'd0, 0, 2'd0, 0, 0, 0, 24'h000123, 0);
    // R4 R5: cascade paths
    drive("R4 pcin",     1, 0, 0, 2'd0, 2'd0, 3'd1, 0, 2'd0, 0, 0, 0, 0, 24'h8A0000);
    drive("R5 pcin>>17", 1, 0, 0, 2'd0, 2'd0, 3'd5, 0, 2'd0, 0, 0, 0, 0, 24'h8A0000);
    drive("R4 load neg", 1, 0, 0, 2'd0, 2'd0, 3'd3, 0, 2'd0, 0, 0, 0, 24'hC40000, 0);
    drive("R5 p>>17",    1, 0, 0, 2'd0, 2'd0, 3'd6, 0, 2'd0, 0, 0, 0, 0, 0);
    // R6: subtract
    drive("R6 sub",      1, 0, 1, 2'd1, 2'd3, 3'd3, 0, 2'd0, 12'd20, 12'd5, 9'd3, 24'd1000, 0);
    // R7: enable low holds
    drive("R7 hold",     0, 0, 0, 2'd1, 2'd0, 3'd0, 0, 2'd0, 12'd99, 12'd1, 9'd9, 0, 0);
    // R8: illegal Z code holds and flags
    drive("R8 illegal",  1, 0, 0, 2'd1, 2'd0, 3'd7, 0, 2'd0, 12'd99, 12'd1, 9'd9, 0, 0);
    // R9: masked compare, constant then c as reference
    drive("R9 const hit", 1, 0, 0, 2'd0, 2'd0, 3'd3, 0, 2'd0, 0, 0, 0, 24'h123ABC, 0);
    drive("R9 c miss",   1, 0, 0, 2'd0, 2'd0, 3'd2, 1, 2'd0, 0, 0, 0, 24'hFFF555, 0);
    drive("R9 c hit",    1, 0, 0, 2'd0, 2'd0, 3'd2, 1, 2'd0, 0, 0, 0, 24'h000ABC, 0);
    // R10: auto-clear on match, then on mismatch, then mode 11 no clear
    drive("R10 clr hit", 1, 0, 0, 2'd0, 2'd0, 3'd2, 0, 2'd1, 0, 0, 0, 0, 0);
    drive("R10 clr miss", 1, 0, 0, 2'd0, 2'd0, 3'd3, 0, 2'd2, 0, 0, 0, 24'd77, 0);
    drive("R10 mode 11", 1, 0, 0, 2'd0, 2'd0, 3'd3, 0, 2'd3, 0, 0, 0, 24'd77, 0);
    drive("R10 miss idle", 0, 0, 0, 2'd0, 2'd0, 3'd3, 0, 2'd2, 0, 0, 0, 24'd5, 0);
    drive("R6 idle",     0, 0, 0, 2'd0, 2'd0, 3'd0, 0, 2'd0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule